// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This block divides one unsigned integer by another. It gives a quotient and a remainder by taking the divisor away from a working value once per clock. It is meant for a small calculator whose operands never go past 999, so the default operand width is 10 bits. The time an operation takes depends on its data. With quotient q, the result is ready q+1 clocks after the operation is accepted. A zero divisor is the exception: it finishes after a single clock and raises an error flag, so the block can never spin forever.

The host sets `num` and `den` and raises `start` for one cycle while `busy` is low. That edge captures both operands. `busy` then stays high while subtractions run. When the working value drops below the divisor, `busy` falls and `done` rises in the same cycle. `done`, `quot`, `rem` and `div_err` then hold until the next accepted `start`. `busy` acts as back-pressure for requests: a `start` seen while `busy` is high is dropped and does not disturb the running operation. A new `start` may be issued in any cycle where `busy` is low, including while `done` is still high.

Top module: `repsub_div`

## Requirements
- R1: After reset, `busy`, `done`, `div_err`, `quot` and `rem` are all zero.
- R2: For a nonzero divisor, a completed operation gives `quot` = floor(num/den) and `rem` = num − quot·den, with `rem` < `den`.
- R3: A `start` is accepted at a clock edge where `busy` is low. For a nonzero divisor, `done` first reads high after the (q+1)-th edge following the accepting edge, where q is the quotient.
- R4: From the edge after acceptance until completion, `busy` is high and `done` is low. Each clock in this period performs one subtraction and adds one to `quot`.
- R5: A `start` that arrives while `busy` is high is ignored. The result reflects only the operands that were captured at acceptance.
- R6: While `done` is high and `start` is low, `done`, `quot`, `rem` and `div_err` stay unchanged.
- R7: An accepted `start` clears `done` on the next edge. This includes a `start` given while `done` is high.
- R8: A zero divisor completes on the accepting edge itself. The result is `done`=1, `div_err`=1, `quot`=0 and `rem`=num.
- R9: `div_err` is cleared by the next accepted `start` whose divisor is nonzero.
- R10: A dividend smaller than the divisor, including zero, gives `quot`=0 and `rem`=num after one clock of `busy`. A divisor of 1 with a dividend of 999 gives 999 with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted only while busy is low |
| num | input | W (10) | Dividend, captured on acceptance |
| den | input | W (10) | Divisor, captured on acceptance |
| busy | output | 1 | Subtraction loop running; requests are dropped |
| done | output | 1 | Result valid, held until next accepted start |
| div_err | output | 1 | Last operation had a zero divisor |
| quot | output | W (10) | Quotient |
| rem | output | W (10) | Remainder |

## Verification
The risky overlap is a new request landing in the same cycle as the loop's final comparison. In that cycle `busy` is still high while the working value has already dropped below the divisor. The bench raises a second `start`, with different operands, exactly on the last busy cycle of a 500/3 run. That request must be dropped: `done` must rise at the usual q+1 count and the result must still be 166 remainder 2. A second overlap is a restart issued while `done` is held high. It is judged by `busy` rising and `done` falling on the next edge, followed by a fresh, correct result.

// File: rtl/repsub_div_pkg.sv
package repsub_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } div_state_e;
endpackage

// File: rtl/repsub_div_ctrl.sv
module repsub_div_ctrl
  import repsub_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic den_is_zero,
  input  logic work_ge_den,
  output logic load,
  output logic step,
  output logic busy,
  output logic done,
  output logic div_err
);
  div_state_e state_q, state_d;
  logic       err_q, err_d;

  assign busy    = (state_q == ST_RUN);
  assign done    = (state_q == ST_HOLD);
  assign div_err = err_q;
  assign load    = start && !busy;
  assign step    = busy && work_ge_den;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_RUN: begin
        if (!work_ge_den) state_d = ST_HOLD;
      end
      default: begin
        if (start) begin
          state_d = den_is_zero ? ST_HOLD : ST_RUN;
          err_d   = den_is_zero;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/repsub_div_path.sv
module repsub_div_path #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         den_is_zero,
  output logic         work_ge_den,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic [W-1:0] den_q
);
  logic [W-1:0] work_q, quot_q, dhold_q;
  logic [W-1:0] diff;

  assign den_is_zero = (den == '0);
  assign work_ge_den = (work_q >= dhold_q);
  assign diff        = work_q - dhold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      quot_q  <= '0;
      dhold_q <= '0;
    end else if (load) begin
      work_q  <= num;
      quot_q  <= '0;
      dhold_q <= den;
    end else if (step) begin
      work_q  <= diff;
      quot_q  <= quot_q + W'(1);
    end
  end

  assign quot  = quot_q;
  assign rem   = work_q;
  assign den_q = dhold_q;
endmodule

// File: rtl/repsub_div.sv
module repsub_div
  import repsub_div_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic         load, step, den_is_zero, work_ge_den;
  logic [W-1:0] den_q;

  repsub_div_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .den_is_zero (den_is_zero),
    .work_ge_den (work_ge_den),
    .load        (load),
    .step        (step),
    .busy        (busy),
    .done        (done),
    .div_err     (div_err)
  );

  repsub_div_path #(.W(W)) u_path (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .step        (step),
    .num         (num),
    .den         (den),
    .den_is_zero (den_is_zero),
    .work_ge_den (work_ge_den),
    .quot        (quot),
    .rem         (rem),
    .den_q       (den_q)
  );
endmodule

// File: rtl/repsub_div_chk.sv
module repsub_div_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] num,
  input logic [W-1:0] den,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] quot,
  input logic [W-1:0] rem,
  input logic [W-1:0] den_q
);
  a_r4_busy_not_done: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    (busy && rem >= den_q) |=> (busy && quot == $past(quot) + W'(1)));

  a_r5_operands_kept: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(den_q));

  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    (done && !div_err) |-> (rem < den_q));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(quot) && $stable(rem) && $stable(div_err)));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (done && start && den != '0) |=> (busy && !done));

  a_r8_zero_den: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && den == '0) |=> (done && div_err && quot == '0 && rem == $past(num)));
endmodule

bind repsub_div repsub_div_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .num     (num),
  .den     (den),
  .busy    (busy),
  .done    (done),
  .div_err (div_err),
  .quot    (quot),
  .rem     (rem),
  .den_q   (den_q)
);

// File: tb/repsub_div_tb_top.sv
`timescale 1ns/1ps
module repsub_div_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] num = '0;
  logic [W-1:0] den = '0;
  logic         busy, done, div_err;
  logic [W-1:0] quot, rem;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  repsub_div #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .num(num), .den(den),
    .busy(busy), .done(done), .div_err(div_err), .quot(quot), .rem(rem)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual hung expected finish");
      errors = errors + 1;
      report();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Issue a division; optionally inject an extra start at busy-cycle index inj_at.
  task automatic run_div(input int n, input int d, input int inj_at, input string name);
    int cnt;
    int q, r;
    q = (d == 0) ? 0 : n / d;
    r = (d == 0) ? n : n % d;
    @(negedge clk);
    num = W'(n); den = W'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    num = W'(n + 3); den = W'(d + 1);
    cnt = 0;
    if (d != 0) check(busy == 1'b1 && done == 1'b0, {name, " R4 busy after accept"}, busy, 1);
    while (!done && cnt < 2000) begin
      if (cnt == inj_at) begin
        num = W'(77); den = W'(4); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    if (d == 0) begin
      check(cnt == 0, {name, " R8 one-cycle finish"}, cnt, 0);
      check(div_err == 1'b1, {name, " R8 err flag"}, div_err, 1);
      check(quot == 0, {name, " R8 quot"}, quot, 0);
      check(rem == W'(n), {name, " R8 rem"}, rem, n);
    end else begin
      check(cnt == q + 1, {name, " R3 latency"}, cnt, q + 1);
      check(quot == W'(q), {name, " R2 quot"}, quot, q);
      check(rem == W'(r), {name, " R2 rem"}, rem, r);
      check(div_err == 1'b0, {name, " R9 err clear"}, div_err, 0);
      check(busy == 1'b0, {name, " R4 busy low at done"}, busy, 0);
    end
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && div_err == 0, "R1 flags", {busy, done, div_err}, 0);
    check(quot == 0 && rem == 0, "R1 data", quot + rem, 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    run_div(999, 7, -1, "hold-setup");
    q0 = quot; r0 = rem;
    for (int i = 0; i < 6; i++) begin
      num = W'(i); den = W'(i);
      @(negedge clk);
    end
    check(done == 1 && quot == q0 && rem == r0 && div_err == 0, "R6 held result", quot, q0);
  endtask

  task automatic t_restart_from_done();
    @(negedge clk);
    num = W'(50); den = W'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 0 && busy == 1, "R7 restart clears done", done, 0);
    while (!done) @(negedge clk);
    check(quot == 10 && rem == 0, "R7 restart result", quot, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_div(999, 7, -1, "basic");
    run_div(100, 10, -1, "exact");
    run_div(5, 9, -1, "R10 small");
    run_div(0, 5, -1, "R10 zero-num");
    run_div(999, 1, -1, "R10 max-quot");
    run_div(37, 0, -1, "R8 zero-den");
    run_div(20, 6, -1, "R9 after-err");
    run_div(500, 3, 3, "R5 mid-inject");
    run_div(500, 3, 166, "R5 last-cycle-inject");
    t_hold();
    t_restart_from_done();
    report();
  end
endmodule